// File: doc/BRIEF.md
# Burst Byte-Address Sequencer

This block turns a single burst request into the stream of byte addresses a double-data-rate memory port walks through. A one-cycle start pulse captures a start byte address, a burst mode and a group-length select. From the next cycle the block offers one beat per cycle on a valid/ready output. Each beat names an even byte address and the odd byte right after it, because two bytes move per clock.

Three modes are supported. Wrapped mode stays inside an aligned group of 16, 32, 64 or 128 bytes and finishes after one full pass. Linear mode counts upward without bound. Hybrid mode makes one full wrapped pass and then continues linearly from the first byte of the next group. Unbounded bursts, and any burst cut short, end through a stop input. Back-pressure rule: a beat is accepted on a clock edge where valid and ready are both high. While ready is low, the offered beat and its last flag hold still. The sequencer never withdraws a beat except through stop.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and after reset until the first start, `beat_valid_o` is low.
- R2: A start pulse taken while idle makes `beat_valid_o` high on the next cycle. The first even address is the start address with bit 0 cleared, and `addr_odd_o` is always the even address with bit 0 set.
- R3: The group length is captured at start from `wrap_sel_i`: 0 selects 16 bytes, 1 selects 32, 2 selects 64 and 3 selects 128. In wrapped mode (`mode_i` = 0), each accepted beat adds 2 to the address. At the top of the group the address rolls back to the group base, which is the start address with its low log2(length) bits cleared.
- R4: A wrapped burst has exactly length/2 beats, and `last_o` is high only on the final one. After that beat is accepted, `beat_valid_o` is low on the next cycle.
- R5: In linear mode (`mode_i` = 1; code 3 behaves the same), each accepted beat adds 2 to the address with no roll-back. `last_o` stays low, and beats keep coming until stop.
- R6: In hybrid mode (`mode_i` = 2), the first length/2 beats follow the wrapped sequence of R3. The next beat is at group base plus length, and from there each beat adds 2. `last_o` stays low.
- R7: While `beat_valid_o` is high and `beat_ready_i` is low (stop low), the next cycle still shows valid with the same address and last flag, and the sequence does not advance.
- R8: `stop_i` high during an active burst makes `beat_valid_o` low on the next cycle, in any mode. A new start is accepted after that.
- R9: A start pulse during an active burst is ignored, and the running sequence is unchanged.
- R10: Mode, length select and start address are used only on the start cycle. Changing them later has no effect on the running burst.
- R11: Linear addresses wrap modulo 2^ADDR_W at the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst (taken only when idle) |
| start_addr_i | input | ADDR_W | First byte address of the burst |
| mode_i | input | 2 | 0 wrapped, 1 linear, 2 hybrid, 3 linear |
| wrap_sel_i | input | 2 | Group length: 16 << wrap_sel_i bytes |
| stop_i | input | 1 | End the active burst |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | Consumer accepts the offered beat |
| addr_even_o | output | ADDR_W | Even byte address of the beat |
| addr_odd_o | output | ADDR_W | Odd byte address of the beat |
| last_o | output | 1 | Final beat of a wrapped burst |

## Verification
A corrupted beat counter shows up at the ports within one group pass. A wrapped burst then ends early or late, and `last_o` moves off the length/2-th beat. A hybrid burst jumps to the next group at the wrong beat. A wrong captured base or mask shows on the very next roll-back as an address outside the aligned group. A broken hold path shows in the first stalled cycle as an address that moves while ready is low. The scoreboard compares every accepted address and last flag against a closed-form formula, so a single bad beat is caught on the cycle it is accepted.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    MODE_WRAP   = 2'd0,
    MODE_LINEAR = 2'd1,
    MODE_HYBRID = 2'd2,
    MODE_RSVD   = 2'd3
  } burst_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WRAP = 2'd1,
    ST_LINE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bseq_geom.sv
// Decodes the group-length select into length, offset mask and final beat index.
module bseq_geom #(
  parameter int ADDR_W   = 23,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 4,
  parameter int CNT_W    = 6
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [ADDR_W-1:0] len_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic [CNT_W-1:0]  last_idx_o
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [ADDR_W-1:0] len_tab  [NUM_SEL];
  logic [CNT_W-1:0]  lidx_tab [NUM_SEL];

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    assign len_tab[s]  = ADDR_W'(1) << (MIN_LOG2 + s);
    assign lidx_tab[s] = CNT_W'((1 << (MIN_LOG2 + s - 1)) - 1);
  end

  always_comb begin
    len_o      = len_tab[sel_i];
    mask_o     = len_tab[sel_i] - ADDR_W'(1);
    last_idx_o = lidx_tab[sel_i];
  end
endmodule

// File: rtl/bseq_step.sv
// Next-beat address: wrap inside the group, jump past it, or plain increment.
module bseq_step #(
  parameter int ADDR_W = 23
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              line_phase_i,
  input  logic              pass_end_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] inc;

  always_comb begin
    inc = cur_i + ADDR_W'(2);
    if (line_phase_i)    nxt_o = inc;
    else if (pass_end_i) nxt_o = base_i + len_i;
    else                 nxt_o = base_i | (inc & mask_i);
  end
endmodule

// File: rtl/bseq_ctrl.sv
// Burst state, beat counter within the wrapped pass, handshake.
module bseq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  burst_mode_e      mode_i,
  input  logic [CNT_W-1:0] last_idx_i,
  input  logic             stop_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             load_o,
  output logic             fire_o,
  output logic             line_phase_o,
  output logic             pass_end_o
);
  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lidx_q;
  logic             hyb_q;

  assign valid_o      = (st_q != ST_IDLE);
  assign load_o       = (st_q == ST_IDLE) && start_i;
  assign fire_o       = valid_o && ready_i;
  assign line_phase_o = (st_q == ST_LINE);
  assign pass_end_o   = (st_q == ST_WRAP) && (cnt_q == lidx_q);
  assign last_o       = pass_end_o && !hyb_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_d = '0;
          st_d  = (mode_i == MODE_WRAP || mode_i == MODE_HYBRID) ? ST_WRAP : ST_LINE;
        end
      end
      ST_WRAP: begin
        if (stop_i) st_d = ST_IDLE;
        else if (fire_o) begin
          if (pass_end_o) st_d = hyb_q ? ST_LINE : ST_IDLE;
          else            cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_LINE: if (stop_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      lidx_q <= '0;
      hyb_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (load_o) begin
        lidx_q <= last_idx_i;
        hyb_q  <= (mode_i == MODE_HYBRID);
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  wrap_sel_i,
  input  logic              stop_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] addr_even_o,
  output logic [ADDR_W-1:0] addr_odd_o,
  output logic              last_o
);
  localparam int NUM_SEL  = 1 << SEL_W;
  localparam int MAX_LOG2 = MIN_LOG2 + NUM_SEL - 1;
  localparam int CNT_W    = MAX_LOG2 - 1;

  logic [ADDR_W-1:0] geo_len, geo_mask;
  logic [CNT_W-1:0]  geo_lidx;
  logic [ADDR_W-1:0] addr_q, base_q, mask_q, len_q, nxt;
  logic              load, fire, line_phase, pass_end;

  bseq_geom #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2), .CNT_W(CNT_W)
  ) u_geom (
    .sel_i      (wrap_sel_i),
    .len_o      (geo_len),
    .mask_o     (geo_mask),
    .last_idx_o (geo_lidx)
  );

  bseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (burst_mode_e'(mode_i)),
    .last_idx_i   (geo_lidx),
    .stop_i       (stop_i),
    .ready_i      (beat_ready_i),
    .valid_o      (beat_valid_o),
    .last_o       (last_o),
    .load_o       (load),
    .fire_o       (fire),
    .line_phase_o (line_phase),
    .pass_end_o   (pass_end)
  );

  bseq_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_i        (addr_q),
    .base_i       (base_q),
    .mask_i       (mask_q),
    .len_i        (len_q),
    .line_phase_i (line_phase),
    .pass_end_i   (pass_end),
    .nxt_o        (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      base_q <= '0;
      mask_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      addr_q <= start_addr_i & ~ADDR_W'(1);
      base_q <= start_addr_i & ~geo_mask;
      mask_q <= geo_mask;
      len_q  <= geo_len;
    end else if (fire) begin
      addr_q <= nxt;
    end
  end

  assign addr_even_o = addr_q;
  assign addr_odd_o  = addr_q | ADDR_W'(1);
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [ADDR_W-1:0] addr_even_o,
  input logic              last_o
);
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid_o && start_i) |=> beat_valid_o);

  assert_last_only_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);

  assert_last_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && beat_ready_i && last_o) |=> !beat_valid_o);

  assert_keeps_going_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !last_o && !stop_i) |=> beat_valid_o);

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i && !stop_i) |=>
      (beat_valid_o && $stable(addr_even_o) && $stable(last_o)));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && stop_i) |=> !beat_valid_o);
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_bseq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .addr_even_o  (addr_even_o),
  .last_o       (last_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 23;

  typedef struct {
    logic [AW-1:0] a;
    logic          l;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    mode = 2'd0;
  logic [1:0]    sel = 2'd0;
  logic          stop = 1'b0;
  logic          valid;
  logic          ready = 1'b1;
  logic [AW-1:0] a_even, a_odd;
  logic          last;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  bit   hold = 0;
  bit   bp_en = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .mode_i(mode), .wrap_sel_i(sel), .stop_i(stop), .beat_valid_o(valid),
    .beat_ready_i(ready), .addr_even_o(a_even), .addr_odd_o(a_odd), .last_o(last)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] sa, logic [1:0] md, logic [1:0] sl, int k);
    logic [31:0] len, s, base, off, r;
    int n;
    len  = 32'd16 << sl;
    s    = {9'b0, sa};
    base = s & ~(len - 1);
    off  = s & (len - 1) & ~32'd1;
    n    = int'(len / 2);
    if (md == 2'd1 || md == 2'd3) r = (s & ~32'd1) + 32'(2 * k);
    else if (k < n)               r = base + ((off + 32'(2 * k)) % len);
    else                          r = base + len + 32'(2 * (k - n));
    return r[AW-1:0];
  endfunction

  // ready pattern
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(posedge clk); #2;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ready = hold ? 1'b0 : (bp_en ? (lf[1:0] != 2'b00) : 1'b1);
    end
  end

  // monitor / scoreboard
  logic          p_valid = 0, p_ready = 0, p_stop = 0, p_last = 0;
  logic [AW-1:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_valid && !p_ready && !p_stop) begin
        check(valid === 1'b1 && a_even === p_addr && last === p_last,
              "R7 stall hold", {8'b0, a_even, last}, {8'b0, p_addr, p_last});
      end
      if (valid) check(a_odd === (a_even | 23'd1), "R2 odd pair", {9'b0, a_odd}, {9'b0, a_even | 23'd1});
      if (valid && ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected beat", {9'b0, a_even}, 32'hFFFFFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(a_even === e.a, {e.tag, " addr"}, {9'b0, a_even}, {9'b0, e.a});
          check(last === e.l, {e.tag, " last"}, {31'b0, last}, {31'b0, e.l});
        end
      end
    end
    p_valid = valid; p_ready = ready; p_stop = stop; p_addr = a_even; p_last = last;
  end

  // nbeats = 0 in wrapped mode: run to the natural end; otherwise stop after nbeats
  task automatic run_burst(input logic [AW-1:0] sa, input logic [1:0] md, input logic [1:0] sl,
                           input int nbeats, input bit disturb, input string tag);
    int  full = 8 << sl;
    bit  natural = (md == 2'd0) && (nbeats == 0);
    int  n = natural ? full : nbeats;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.a = exp_addr(sa, md, sl, k);
      e.l = (md == 2'd0) && (k == full - 1);
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    start = 1'b1; start_addr = sa; mode = md; sel = sl;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      // R9, R10: new request and changed controls during a running burst
      mode = ~md; sel = ~sl; start_addr = ~sa; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(posedge clk);
    #1;
    if (natural) begin
      @(negedge clk);
      check(valid === 1'b0, {tag, " R4 end"}, {31'b0, valid}, 32'd0);
    end else begin
      hold = 1'b1; stop = 1'b1;
      @(posedge clk); #1;
      stop = 1'b0; hold = 1'b0;
      @(negedge clk);
      check(valid === 1'b0, {tag, " R8 stop"}, {31'b0, valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0, "R1 in reset", {31'b0, valid}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(valid === 1'b0, "R1 idle", {31'b0, valid}, 32'd0);

    run_burst(23'h000123, 2'd0, 2'd0, 0, 0, "R3 wrap16");
    bp_en = 1;
    run_burst(23'h00003E, 2'd0, 2'd1, 0, 0, "R3 wrap32 edge");
    run_burst(23'h001044, 2'd0, 2'd2, 0, 0, "R3 wrap64");
    run_burst(23'h0000F0, 2'd0, 2'd3, 0, 1, "R10 wrap128 disturb");
    bp_en = 0;
    run_burst(23'h00001D, 2'd1, 2'd0, 20, 0, "R5 linear");
    run_burst(23'h7FFFFA, 2'd1, 2'd2, 6, 0, "R11 top wrap");
    run_burst(23'h00000A, 2'd2, 2'd0, 20, 0, "R6 hybrid16");
    bp_en = 1;
    run_burst(23'h000246, 2'd2, 2'd3, 80, 1, "R6 hybrid128 disturb R9");
    run_burst(23'h000300, 2'd3, 2'd1, 5, 0, "R5 code3");
    run_burst(23'h000452, 2'd0, 2'd1, 3, 0, "R8 early stop wrap");
    bp_en = 0;
    run_burst(23'h000510, 2'd0, 2'd0, 0, 0, "R8 restart");

    repeat (4) @(negedge clk);
    check(valid === 1'b0, "R1 quiet after", {31'b0, valid}, 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule